// File: doc/BRIEF.md
# Standby and AGC Recovery Sequencer

This block is the digital control core of a duty-cycled radio receiver front end. It takes the asynchronous standby request, the sweep/fixed mode select and the two filter-select pins, synchronizes them into the reference clock domain, and produces three kinds of output. The first is the run/standby state. The second is the pair of enables for the AGC capacitor charge pumps. The third is the demodulator filter setting.

While standby is requested, both charge-pump enables are held low. The AGC capacitor then floats and keeps its voltage. When standby is released, the block raises a boost flag for a fixed number of reference cycles. During that window the analog pumps run at a much higher current, so they can quickly restore any droop built up while the receiver was off. With the default count of 2^16 cycles, the window lasts about 10.9 ms at a 6 MHz reference, and its length in time scales inversely with the reference frequency. If standby is requested again during the window, the boost ends at once. The next release starts a full new window.

The filter selection is reported as a divide exponent applied to the widest bandwidth of the current mode: 5 kHz in swept mode and 10 kHz in fixed mode. A separate flag reports the mode.

Top module: `agcseq_ctrl`

## Requirements
- R1: While rst_n is low, each clock edge puts the block in its idle state: run_en=0, agc_push_en=0, agc_pull_en=0, agc_boost=0, sweep_mode=1, bw_div=0. This idle state matches undriven inputs (standby requested, swept mode, widest filter).
- R2: run_en is the inverse of stby_req, delayed by exactly three rising clock edges (two synchronizer stages and one output register).
- R3: agc_push_en and agc_pull_en are both 0 whenever run_en is 0, and both 1 whenever run_en is 1.
- R4: agc_boost rises on the same clock edge as run_en. It then stays high for exactly 2^BOOST_LOG2 cycles (default 65536) and falls while the block keeps running.
- R5: If stby_req is reasserted during a boost window, agc_boost falls on the same edge as run_en. A later release starts a full-length window again.
- R6: agc_boost is never 1 while run_en is 0.
- R7: sweep_mode follows sweep_sel (1 = swept, 0 = fixed), with the same three-edge latency as R2.
- R8: bw_div equals 3 minus {bw_sel[1], bw_sel[0]}. So 11 gives 0 (widest filter), 10 gives 1 (half), 01 gives 2 (quarter) and 00 gives 3 (eighth), with the three-edge latency of R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stby_req | input | 1 | Standby request, asynchronous; 1 = standby |
| sweep_sel | input | 1 | Mode select, asynchronous; 1 = swept LO, 0 = fixed LO |
| bw_sel | input | 2 | Filter select, asynchronous; 11 = widest |
| run_en | output | 1 | 1 = receiver operating, 0 = standby |
| agc_push_en | output | 1 | AGC charge-up pump enable |
| agc_pull_en | output | 1 | AGC charge-down pump enable |
| agc_boost | output | 1 | High-current AGC recovery window active |
| sweep_mode | output | 1 | 1 = swept mode, 0 = fixed mode |
| bw_div | output | 2 | Bandwidth divide exponent, 0 to 3 |

## Verification
Two events can land on the same clock edge: the natural end of the boost count and a new standby request. A further case is a standby request arriving partway through the window. The bench drives stby_req back high a few cycles after boost starts, and checks that agc_boost and both pump enables drop on the same sampled cycle as run_en. It then releases standby again and counts the following boost window cycle by cycle, to show that the full length is restored and not the remainder of the aborted window.

// File: rtl/agcseq_pkg.sv
// Package: shared types and decode helper for the AGC sequencer.
// Assumes: select pins are already synchronized when decoded.
package agcseq_pkg;

    typedef logic [1:0] bw_div_t;

    // Convert the two select bits into a divide exponent; all-ones is widest.
    function automatic bw_div_t sel_to_div(input logic [1:0] sel);
        return bw_div_t'(2'd3 - sel);
    endfunction

endpackage

// File: rtl/agcseq_sync.sv
// Multi-bit level synchronizer for slow, independent control pins.
// Assumes: every bit is a quasi-static level; no cross-bit coherence is needed.
module agcseq_sync #(
    parameter int              WIDTH   = 1,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);

    logic [WIDTH-1:0] chain [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            // One flop stage of the synchronizer chain.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain[s] <= RST_VAL;
                end else if (s == 0) begin
                    chain[s] <= d_async;
                end else begin
                    chain[s] <= chain[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/agcseq_bw_decode.sv
// Registers the mode flag and the filter divide exponent.
// Assumes: inputs come from the synchronizer.
module agcseq_bw_decode
    import agcseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sweep_s,
    input  logic [1:0] sel_s,
    output logic       sweep_mode,
    output bw_div_t    bw_div
);

    // Register the decoded filter setting and the mode flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sweep_mode <= 1'b1;
            bw_div     <= '0;
        end else begin
            sweep_mode <= sweep_s;
            bw_div     <= sel_to_div(sel_s);
        end
    end

    AST_MODE_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (sweep_mode == $past(sweep_s))) else $error("mode"); // R7

endmodule

// File: rtl/agcseq_pump_gate.sv
// Produces the run enable and gates both AGC charge pumps with standby.
// Assumes: shut_s is the synchronized standby request.
module agcseq_pump_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic shut_s,
    output logic run_en,
    output logic push_en,
    output logic pull_en
);

    // Run state and pump enables, all off in standby so the capacitor floats.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_en  <= 1'b0;
            push_en <= 1'b0;
            pull_en <= 1'b0;
        end else begin
            run_en  <= !shut_s;
            push_en <= !shut_s;
            pull_en <= !shut_s;
        end
    end

endmodule

// File: rtl/agcseq_boost_timer.sv
// Times the high-current AGC recovery window after each standby release.
// Assumes: shut_s is synchronized; the window is 2**BOOST_LOG2 cycles long.
module agcseq_boost_timer #(
    parameter int BOOST_LOG2 = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic shut_s,
    output logic boost
);

    localparam logic [BOOST_LOG2-1:0] LOAD_VAL = '1;

    logic                  shut_d;
    logic [BOOST_LOG2-1:0] remain;

    // Keep the previous standby level to detect the release.
    always_ff @(posedge clk) begin
        if (!rst_n) shut_d <= 1'b1;
        else        shut_d <= shut_s;
    end

    // Start, count down, or abort the boost window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            boost  <= 1'b0;
            remain <= '0;
        end else if (shut_s) begin
            boost  <= 1'b0;
            remain <= '0;
        end else if (shut_d) begin
            boost  <= 1'b1;
            remain <= LOAD_VAL;
        end else if (boost) begin
            if (remain == '0) boost <= 1'b0;
            else              remain <= remain - 1'b1;
        end
    end

    AST_IDLE_CNT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !boost |-> (remain == '0)) else $error("idle count"); // R4
    AST_ABORT_ON_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
        shut_s |=> !boost) else $error("abort"); // R5

endmodule

// File: rtl/agcseq_ctrl.sv
// Top: standby/AGC recovery sequencer for a duty-cycled receiver.
// Assumes: all control pins are asynchronous levels; undriven pins read high.
module agcseq_ctrl #(
    parameter int SYNC_STAGES = 2,
    parameter int BOOST_LOG2  = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stby_req,
    input  logic       sweep_sel,
    input  logic [1:0] bw_sel,
    output logic       run_en,
    output logic       agc_push_en,
    output logic       agc_pull_en,
    output logic       agc_boost,
    output logic       sweep_mode,
    output logic [1:0] bw_div
);

    localparam int PIN_W = 4;

    logic [PIN_W-1:0] pins_s;
    logic             shut_s;
    logic             sweep_s;
    logic [1:0]       sel_s;

    agcseq_sync #(
        .WIDTH  (PIN_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL(4'b1111)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_async({stby_req, sweep_sel, bw_sel}),
        .q_sync (pins_s)
    );

    assign shut_s  = pins_s[3];
    assign sweep_s = pins_s[2];
    assign sel_s   = pins_s[1:0];

    agcseq_pump_gate u_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .shut_s (shut_s),
        .run_en (run_en),
        .push_en(agc_push_en),
        .pull_en(agc_pull_en)
    );

    agcseq_boost_timer #(
        .BOOST_LOG2(BOOST_LOG2)
    ) u_boost (
        .clk   (clk),
        .rst_n (rst_n),
        .shut_s(shut_s),
        .boost (agc_boost)
    );

    agcseq_bw_decode u_bw (
        .clk       (clk),
        .rst_n     (rst_n),
        .sweep_s   (sweep_s),
        .sel_s     (sel_s),
        .sweep_mode(sweep_mode),
        .bw_div    (bw_div)
    );

    AST_PUMPS_OFF_STBY: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |-> (!agc_push_en && !agc_pull_en)) else $error("pumps"); // R3
    AST_BOOST_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        agc_boost |-> run_en) else $error("boost in standby"); // R6
    AST_BOOST_ON_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_en) |-> agc_boost) else $error("boost start"); // R4

endmodule

// File: tb/agcseq_ctrl_bench.sv
module agcseq_ctrl_bench;

    localparam int BL2  = 5;
    localparam int BLEN = 1 << BL2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       stby_req = 1'b1;
    logic       sweep_sel = 1'b1;
    logic [1:0] bw_sel = 2'b11;
    logic       run_en, agc_push_en, agc_pull_en, agc_boost, sweep_mode;
    logic [1:0] bw_div;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    agcseq_ctrl #(.SYNC_STAGES(2), .BOOST_LOG2(BL2)) u_agcseq_ctrl (
        .clk(clk), .rst_n(rst_n), .stby_req(stby_req), .sweep_sel(sweep_sel),
        .bw_sel(bw_sel), .run_en(run_en), .agc_push_en(agc_push_en),
        .agc_pull_en(agc_pull_en), .agc_boost(agc_boost),
        .sweep_mode(sweep_mode), .bw_div(bw_div)
    );

    // {stby, sweep, sel1, sel0, exp_run, exp_mode, exp_div[1:0]}
    localparam logic [7:0] VEC [0:7] = '{
        8'b0_1_11_1_1_00, 8'b0_1_10_1_1_01, 8'b0_0_01_1_0_10, 8'b0_0_00_1_0_11,
        8'b1_0_11_0_0_00, 8'b1_1_00_0_1_11, 8'b0_1_01_1_1_10, 8'b0_0_10_1_0_01
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_neg(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int n;
        // R1: idle state under reset
        wait_neg(4);
        chk("R1 run_en", run_en, 0);
        chk("R1 push/pull", {agc_push_en, agc_pull_en}, 0);
        chk("R1 boost", agc_boost, 0);
        chk("R1 sweep_mode", sweep_mode, 1);
        chk("R1 bw_div", bw_div, 0);
        rst_n = 1'b1;
        wait_neg(4);

        // Table walk: R2, R3, R7, R8
        for (int i = 0; i < 8; i++) begin
            {stby_req, sweep_sel, bw_sel} = VEC[i][7:4];
            wait_neg(2);
            chk("R2 latency hold", run_en, (i == 0 || i == 6) ? 0 : VEC[i-1][3]);
            wait_neg(1);
            chk("R2 run_en", run_en, VEC[i][3]);
            chk("R3 pumps", {agc_push_en, agc_pull_en}, {2{VEC[i][3]}});
            chk("R7 sweep_mode", sweep_mode, VEC[i][2]);
            chk("R8 bw_div", bw_div, VEC[i][1:0]);
            wait_neg(BLEN + 2);
        end

        // R4: full window length from a standby release
        stby_req = 1'b1;
        wait_neg(6);
        chk("R6 boost in standby", agc_boost, 0);
        stby_req = 1'b0;
        wait_neg(2);
        chk("R4 boost before wake", agc_boost, 0);
        wait_neg(1);
        chk("R4 boost with run", {run_en, agc_boost}, 2'b11);
        n = 0;
        while (agc_boost && n < 4 * BLEN) begin n++; wait_neg(1); end
        chk("R4 window length", n, BLEN);
        chk("R4 still running", run_en, 1);
        wait_neg(10);
        chk("R4 boost stays low", agc_boost, 0);

        // R5: abort window then full restart
        stby_req = 1'b1;
        wait_neg(6);
        stby_req = 1'b0;
        wait_neg(3 + 5);
        stby_req = 1'b1;
        wait_neg(2);
        chk("R5 boost before abort", agc_boost, 1);
        wait_neg(1);
        chk("R5 abort boost", agc_boost, 0);
        chk("R5 abort run", run_en, 0);
        chk("R5 pumps off", {agc_push_en, agc_pull_en}, 0);
        wait_neg(4);
        stby_req = 1'b0;
        wait_neg(3);
        n = 0;
        while (agc_boost && n < 4 * BLEN) begin n++; wait_neg(1); end
        chk("R5 restart full window", n, BLEN);

        // R1: reset mid-window returns to idle
        stby_req = 1'b1; wait_neg(6); stby_req = 1'b0; wait_neg(5);
        rst_n = 1'b0;
        wait_neg(1);
        chk("R1 reset drops boost", agc_boost, 0);
        chk("R1 reset drops run", run_en, 0);
        rst_n = 1'b1;

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule